// File: doc/BRIEF.md
# Lockable Round-Robin Resource Allocator

This block hands out a set of shared resources, such as output virtual channels or output ports of a router, to a set of requestors. Each resource has its own arbiter and its own request vector, with one line for each requestor. Each cycle, each resource picks at most one requestor by rotating priority. A per-resource ready input can keep a resource from being granted at all. The number of requestors and the number of resources are parameters.

A requestor that wins a resource can keep it by raising its lock bit for that resource. While the lock stays high, no other requestor can take the resource. When the lock is released, arbitration starts again at the requestor after the one that held it. For each resource the block reports a grant-valid flag and the binary index of the winner.

The block does not resolve conflicts across resources. One requestor may win several resources in the same cycle, and a downstream stage is expected to handle that.

Top module: `lock_rr_alloc`

## Requirements
- R1: Each resource grants at most one requestor per cycle. It grants only a requestor whose request bit for that resource is high. That bit sits at position r*NUM_REQ+q of `req_i`. The resources do not affect one another.
- R2: While a resource's ready bit is low, its grant-valid output is low. Its rotation pointer and its held ownership stay unchanged.
- R3: Suppose a resource is granted to requestor q while bit q of that resource's lock field in `lock_i` is high (same layout as `req_i`). On every later cycle in which that lock bit stays high, the resource goes only to q. q is granted when it requests, and nobody is granted otherwise. The holding survives cycles in which ready is low.
- R4: For resource r, the grant flag is bit r of `gnt_vld_o`. The winner's binary index is the field `chosen_o[r*IDX_W +: IDX_W]`, with IDX_W = ceil(log2(NUM_REQ)) (minimum 1). The field reads 0 whenever the flag is low.
- R5: When no lock is holding a resource, the winner is the first requesting index found by searching upward from the rotation pointer, wrapping from NUM_REQ-1 to 0.
- R6: The pointer becomes (winner+1) mod NUM_REQ only on a grant made by arbitration. Grants made by a held lock, and cycles with no grant, leave the pointer unchanged.
- R7: On the first cycle in which the holder's lock bit is low, the resource is arbitrated normally. The search starts at the requestor after the previous holder.
- R8: After reset, no resource is held and every pointer is at requestor 0.
- R9: A lock bit raised by a requestor that does not hold the resource has no effect on that resource's grants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | NUM_RES*NUM_REQ | Request bits, resource-major |
| lock_i | input | NUM_RES*NUM_REQ | Lock bits, same layout as req_i |
| ready_i | input | NUM_RES | Resource may be allocated this cycle |
| gnt_vld_o | output | NUM_RES | Resource granted this cycle |
| chosen_o | output | NUM_RES*IDX_W | Binary index of the winner per resource |

## Verification
The assertions check, on every cycle:
- ready gating;
- that a grant goes only to a requesting index inside the legal range;
- that the index field is zero when no grant is given;
- that a held resource stays with its locking owner from one cycle to the next.

The directed scenarios check the behaviour that depends on history:
- the exact rotation order for full and sparse request patterns;
- that the pointer does not move during ready-low cycles or locked grants;
- where arbitration restarts after a lock is released;
- that lock bits from non-holders are ignored;
- that the resources are independent of one another.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

  // Width of a binary requestor index, never below one bit.
  function automatic int unsigned idx_w(input int unsigned n);
    int unsigned w;
    w = 1;
    while ((1 << w) < n) w++;
    return w;
  endfunction

endpackage

// File: rtl/lsa_rr_pick.sv
// Rotating-priority search: first requesting index at or above ptr_i, wrapping.
module lsa_rr_pick #(
  parameter int unsigned NUM_REQ = 4,
  parameter int unsigned IDX_W   = lsa_pkg::idx_w(NUM_REQ)
) (
  input  logic [NUM_REQ-1:0] req_i,
  input  logic [IDX_W-1:0]   ptr_i,
  output logic               vld_o,
  output logic [IDX_W-1:0]   idx_o
);

  always_comb begin
    vld_o = 1'b0;
    idx_o = '0;
    // Walk from farthest to nearest offset so the nearest request wins.
    for (int i = NUM_REQ - 1; i >= 0; i--) begin
      int k;
      k = int'(ptr_i) + i;
      if (k >= int'(NUM_REQ)) k = k - int'(NUM_REQ);
      if (req_i[k]) begin
        vld_o = 1'b1;
        idx_o = IDX_W'(k);
      end
    end
  end

endmodule

// File: rtl/lsa_slot.sv
// One resource: rotating arbiter, ready gate and lock-based ownership.
module lsa_slot #(
  parameter int unsigned NUM_REQ = 4,
  parameter int unsigned IDX_W   = lsa_pkg::idx_w(NUM_REQ)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] req_i,
  input  logic [NUM_REQ-1:0] lock_i,
  input  logic               ready_i,
  output logic               gnt_vld_o,
  output logic [IDX_W-1:0]   chosen_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REQ - 1);

  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic [IDX_W-1:0] owner_q, owner_d;
  logic             held_q, held_d;
  logic             ptr_en, owner_en;

  logic             hold;
  logic             pick_vld;
  logic [IDX_W-1:0] pick_idx;
  logic [IDX_W-1:0] win_idx;
  logic             gnt;

  lsa_rr_pick #(.NUM_REQ(NUM_REQ), .IDX_W(IDX_W)) u_pick (
    .req_i (req_i),
    .ptr_i (ptr_q),
    .vld_o (pick_vld),
    .idx_o (pick_idx)
  );

  // Ownership holds only while the recorded owner keeps its lock raised.
  always_comb begin
    hold    = held_q & lock_i[owner_q];
    win_idx = hold ? owner_q : pick_idx;
    gnt     = ready_i & (hold ? req_i[owner_q] : pick_vld);
  end

  // Next state and clock enables.
  always_comb begin
    ptr_en   = gnt & ~hold;
    owner_en = gnt;
    ptr_d    = (win_idx == LAST_IDX) ? '0 : win_idx + IDX_W'(1);
    owner_d  = win_idx;
    held_d   = gnt ? lock_i[win_idx] : hold;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      owner_q <= '0;
      held_q  <= 1'b0;
    end else begin
      held_q <= held_d;
      if (ptr_en)   ptr_q   <= ptr_d;
      if (owner_en) owner_q <= owner_d;
    end
  end

  assign gnt_vld_o = gnt;
  assign chosen_o  = gnt ? win_idx : '0;

  // R2: a resource that is not ready grants nobody.
  p_ready_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_i |-> !gnt_vld_o);

  // R1: a grant goes only to a requesting index.
  p_grant_has_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld_o |-> req_i[chosen_o]);

  // R4: index in range, and zero when no grant is given.
  p_idx_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld_o |-> (int'(chosen_o) < int'(NUM_REQ)));
  p_idx_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !gnt_vld_o |-> (chosen_o == '0));

  // R3: a locked winner keeps the resource while its lock stays high.
  p_lock_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_vld_o && lock_i[chosen_o]) |=>
      (!gnt_vld_o || !lock_i[$past(chosen_o)] || chosen_o == $past(chosen_o)));

endmodule

// File: rtl/lock_rr_alloc.sv
module lock_rr_alloc #(
  parameter int unsigned NUM_REQ = 4,
  parameter int unsigned NUM_RES = 3,
  localparam int unsigned IDX_W  = lsa_pkg::idx_w(NUM_REQ)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_RES*NUM_REQ-1:0] req_i,
  input  logic [NUM_RES*NUM_REQ-1:0] lock_i,
  input  logic [NUM_RES-1:0]         ready_i,
  output logic [NUM_RES-1:0]         gnt_vld_o,
  output logic [NUM_RES*IDX_W-1:0]   chosen_o
);

  // Reset asserts at once and is released on the second clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  for (genvar r = 0; r < NUM_RES; r++) begin : g_res
    lsa_slot #(.NUM_REQ(NUM_REQ), .IDX_W(IDX_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .req_i     (req_i[r*NUM_REQ +: NUM_REQ]),
      .lock_i    (lock_i[r*NUM_REQ +: NUM_REQ]),
      .ready_i   (ready_i[r]),
      .gnt_vld_o (gnt_vld_o[r]),
      .chosen_o  (chosen_o[r*IDX_W +: IDX_W])
    );
  end

endmodule

// File: tb/lock_rr_alloc_bench.sv
module lock_rr_alloc_bench;

  localparam int NQ = 4;
  localparam int NR = 3;
  localparam int IW = 2;

  logic            clk;
  logic            rst_n;
  logic [NR*NQ-1:0] req_v, lock_v;
  logic [NR-1:0]    rdy_v;
  logic [NR-1:0]    vld;
  logic [NR*IW-1:0] chosen;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  lock_rr_alloc #(.NUM_REQ(NQ), .NUM_RES(NR)) u_lock_rr_alloc (
    .clk(clk), .rst_n(rst_n), .req_i(req_v), .lock_i(lock_v),
    .ready_i(rdy_v), .gnt_vld_o(vld), .chosen_o(chosen)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input int r, input bit ev, input int ei, input string tag);
    logic       av;
    logic [1:0] ai;
    av = vld[r];
    ai = chosen[r*IW +: IW];
    n_tests++;
    if (av !== ev || (ev && int'(ai) != ei) || (!ev && ai !== 2'd0)) begin
      n_fail++;
      $display("FAIL %s res%0d: vld=%0b idx=%0d expected vld=%0b idx=%0d",
               tag, r, av, ai, ev, ev ? ei : 0);
    end
  endtask

  // Drive at a negedge, look after settling, then pass one posedge.
  task automatic drive(input int r, input logic [NQ-1:0] rq, input logic [NQ-1:0] lk);
    req_v[r*NQ +: NQ]  = rq;
    lock_v[r*NQ +: NQ] = lk;
  endtask
  task automatic settle; #2; endtask
  task automatic next_cycle; @(negedge clk); endtask

  task automatic do_reset;
    req_v = '0; lock_v = '0; rdy_v = '1;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset_state; // R8
    do_reset;
    settle;
    for (int r = 0; r < NR; r++) chk(r, 0, 0, "R8 idle after reset");
    drive(0, 4'b1111, 4'b0000); settle;
    chk(0, 1, 0, "R8 pointer starts at 0");
  endtask

  task automatic t_full_rotation; // R5 R6
    int exp_seq[5] = '{0, 1, 2, 3, 0};
    do_reset;
    drive(0, 4'b1111, 4'b0000);
    for (int i = 0; i < 5; i++) begin
      settle; chk(0, 1, exp_seq[i], "R5 full rotation"); next_cycle;
    end
  endtask

  task automatic t_sparse; // R5 R1
    int exp_seq[3] = '{1, 3, 1};
    do_reset;
    drive(0, 4'b1010, 4'b0000);
    for (int i = 0; i < 3; i++) begin
      settle; chk(0, 1, exp_seq[i], "R5 sparse rotation"); next_cycle;
    end
    drive(0, 4'b0000, 4'b0000); settle;
    chk(0, 0, 0, "R1 no request no grant");
  endtask

  task automatic t_ready_gate; // R2 R6
    do_reset;
    drive(0, 4'b1111, 4'b0000);
    rdy_v[0] = 1'b0;
    for (int i = 0; i < 3; i++) begin
      settle; chk(0, 0, 0, "R2 ready low"); next_cycle;
    end
    rdy_v[0] = 1'b1; settle;
    chk(0, 1, 0, "R2 pointer kept through ready low");
  endtask

  task automatic t_lock_hold; // R3 R6 R7
    do_reset;
    drive(0, 4'b1111, 4'b0001);
    settle; chk(0, 1, 0, "R3 first locked grant"); next_cycle;
    for (int i = 0; i < 2; i++) begin
      settle; chk(0, 1, 0, "R3 held by lock"); next_cycle;
    end
    drive(0, 4'b1110, 4'b0001); settle;
    chk(0, 0, 0, "R3 holder idle, others blocked"); next_cycle;
    drive(0, 4'b1111, 4'b0001); rdy_v[0] = 1'b0; settle;
    chk(0, 0, 0, "R3 ready low while held"); next_cycle;
    rdy_v[0] = 1'b1; settle;
    chk(0, 1, 0, "R3 hold survives ready low"); next_cycle;
    drive(0, 4'b1111, 4'b0000); settle;
    chk(0, 1, 1, "R7 release restarts after holder"); next_cycle;
    settle; chk(0, 1, 2, "R6 rotation resumes");
  endtask

  task automatic t_foreign_lock; // R9
    do_reset;
    drive(0, 4'b1111, 4'b1000);
    settle; chk(0, 1, 0, "R9 non-holder lock ignored"); next_cycle;
    settle; chk(0, 1, 1, "R9 rotation unaffected");
  endtask

  task automatic t_independent; // R1 R4
    do_reset;
    drive(0, 4'b0100, 4'b0100);
    drive(1, 4'b1111, 4'b0000);
    drive(2, 4'b1000, 4'b0000);
    settle;
    chk(0, 1, 2, "R1 res0 locked grant");
    chk(1, 1, 0, "R1 res1 own rotation");
    chk(2, 1, 3, "R4 res2 index field");
    next_cycle;
    drive(0, 4'b1111, 4'b0100);
    for (int i = 1; i < 3; i++) begin
      settle;
      chk(0, 1, 2, "R1 res0 stays held");
      chk(1, 1, i, "R1 res1 independent");
      chk(2, 1, 3, "R4 res2 field");
      next_cycle;
    end
  endtask

  initial begin
    req_v = '0; lock_v = '0; rdy_v = '0; rst_n = 1'b0;
    t_reset_state;
    t_full_rotation;
    t_sparse;
    t_ready_gate;
    t_lock_hold;
    t_foreign_lock;
    t_independent;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule